// File: doc/BRIEF.md
# IrDA SIR Pulse Decoder

This block sits between an infrared receiver front end and a host UART. The receiver delivers short active-low pulses on `rxir_i`. A zero bit is a pulse of about three bit-clock ticks at the start of a 16-tick bit slot. A one bit is a slot with no pulse at all. The decoder turns this pulse train back into a UART level stream on `rx_o`, where every bit occupies a full 16 ticks.

The bit clock arrives as a one-cycle enable, `tick_i`, that pulses 16 times per bit period. Baud selection stays outside this block. The pulse input passes through a synchronizer. The frame is timed from the first low sample after a high one, and this tick sets a slot grid that holds for the rest of the frame. Each slot's decision is placed on `rx_o` halfway into the slot, which gives a fixed latency of eight ticks from the start pulse. When the block is disabled, or when command mode is selected, the frame is dropped and `rx_o` rests high.

Top module: `irda_sir_decoder`

## Requirements
- R1: While `rst_ni` is low and after it is released, with no frame under way, `rx_o` is high (idle level).
- R2: A frame starts on the first `tick_i` at which the synchronized `rxir_i` is low after being high on the previous tick. `rx_o` falls to 0 (start bit) exactly 8 ticks later, that is, on the clock edge of the eighth following tick.
- R3: A data slot whose synchronized `rxir_i` is low on any of its first 8 ticks (slot ticks 0 to 7) decodes as 0.
- R4: A data slot with no low sample in ticks 0 to 7 decodes as 1, even if a pulse occurs in ticks 8 to 15 of that slot.
- R5: Slot n begins 16×n ticks after the start tick. The decoded value of slot n is driven from tick 16×n+8 and held for exactly 16 ticks. The slots are start, then data bits 0 to 7 in order of arrival. `rx_o` changes at no other tick.
- R6: At tick 152 (slot 9, tick 8) `rx_o` is driven high as the stop bit and the decoder returns to idle. A new frame then needs `rxir_i` to be sampled high on a tick before it is sampled low again, so a line held low does not start a second frame.
- R7: While `en_i` is low or `cmd_mode_i` is high, the decoder is held idle, `rx_o` is high from the next clock, any frame under way is dropped, and pulses on `rxir_i` have no effect.
- R8: The decoder state and `rx_o` advance only on clocks where `tick_i` is high (apart from R7). `rxir_i` passes through two synchronizer flops before it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-clock enable, 16 pulses per bit period |
| en_i | input | 1 | Decoder enable, high to run |
| cmd_mode_i | input | 1 | High selects command mode; the decoder is held idle |
| rxir_i | input | 1 | Pulse input from the IR receiver, active low, asynchronous |
| rx_o | output | 1 | Decoded UART-format serial output, idle high |

## Verification
A wrong tick count or slot index moves the point where `rx_o` changes away from tick 8 of a slot. This shows up on the first data bit whose value differs from its neighbour, within 24 ticks of the start pulse. A pulse flag that is not cleared, or that is set too late, inverts a data bit and is visible for all 16 ticks of that bit. A fault in the stop slot or in re-arming either keeps `rx_o` low past tick 152 or lets a held-low line start a second frame, which is seen at most one frame later.

// File: rtl/sir_dec_pkg.sv
package sir_dec_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dec_state_e;
endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sir_start_det.sv
module sir_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_i,
  input  logic ir_i,
  output logic start_o
);
  // level of the line at the previous tick; reset low so a stuck-low line never starts
  logic last_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_hi_q <= 1'b0;
    else if (tick_i) last_hi_q <= ir_i;
  end

  assign start_o = tick_i & arm_i & last_hi_q & ~ir_i;
endmodule

// File: rtl/sir_slot_timer.sv
module sir_slot_timer
  import sir_dec_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_SLOTS   = 10,
  localparam int CNT_W  = $clog2(TICKS_PER_BIT),
  localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              start_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              sample_o,
  output logic              load_o,
  output logic              last_o
);
  localparam logic [CNT_W-1:0]  HALF_C = CNT_W'(TICKS_PER_BIT / 2);
  localparam logic [CNT_W-1:0]  END_C  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [SLOT_W-1:0] LAST_C = SLOT_W'(FRAME_SLOTS - 1);

  dec_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic              run_tick;

  assign run_tick = (state_q == ST_RUN) && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
    end else if (start_i && state_q == ST_IDLE) begin
      // start tick counts as tick 0 of slot 0
      state_q <= ST_RUN;
      cnt_q   <= CNT_W'(1);
      slot_q  <= '0;
    end else if (run_tick) begin
      if (cnt_q == HALF_C && slot_q == LAST_C) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        slot_q  <= '0;
      end else if (cnt_q == END_C) begin
        cnt_q  <= '0;
        slot_q <= slot_q + SLOT_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign active_o = (state_q == ST_RUN);
  assign cnt_o    = cnt_q;
  assign slot_o   = slot_q;
  assign sample_o = run_tick && (cnt_q < HALF_C);
  assign load_o   = run_tick && (cnt_q == HALF_C);
  assign last_o   = (slot_q == LAST_C);
endmodule

// File: rtl/sir_bit_judge.sv
module sir_bit_judge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  input  logic sample_i,
  input  logic ir_i,
  input  logic load_i,
  input  logic stop_i,
  output logic rx_o
);
  logic pulse_q;
  logic rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pulse_q <= 1'b0;
    else if (clr_i)             pulse_q <= 1'b0;
    else if (start_i)           pulse_q <= 1'b1;
    else if (load_i)            pulse_q <= 1'b0;
    else if (sample_i && !ir_i) pulse_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_q <= 1'b1;
    else if (clr_i)  rx_q <= 1'b1;
    else if (load_i) rx_q <= stop_i ? 1'b1 : ~pulse_q;
  end

  assign rx_o = rx_q;
endmodule

// File: rtl/irda_sir_decoder.sv
module irda_sir_decoder #(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_BITS     = 8,
  parameter int SYNC_STAGES   = 2,
  localparam int FRAME_SLOTS  = DATA_BITS + 2,
  localparam int CNT_W        = $clog2(TICKS_PER_BIT),
  localparam int SLOT_W       = $clog2(FRAME_SLOTS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic cmd_mode_i,
  input  logic rxir_i,
  output logic rx_o
);
  logic              hold_off;
  logic              ir_s;
  logic              start;
  logic              run_active;
  logic [CNT_W-1:0]  tick_cnt;
  logic [SLOT_W-1:0] slot_idx;
  logic              sample;
  logic              load;
  logic              last_slot;

  assign hold_off = ~en_i | cmd_mode_i;

  sir_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxir_i),
    .q_o   (ir_s)
  );

  sir_start_det u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .arm_i  (~run_active & ~hold_off),
    .ir_i   (ir_s),
    .start_o(start)
  );

  sir_slot_timer #(.TICKS_PER_BIT(TICKS_PER_BIT), .FRAME_SLOTS(FRAME_SLOTS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clr_i   (hold_off),
    .start_i (start),
    .active_o(run_active),
    .cnt_o   (tick_cnt),
    .slot_o  (slot_idx),
    .sample_o(sample),
    .load_o  (load),
    .last_o  (last_slot)
  );

  sir_bit_judge u_judge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hold_off),
    .start_i (start),
    .sample_i(sample),
    .ir_i    (ir_s),
    .load_i  (load),
    .stop_i  (last_slot),
    .rx_o    (rx_o)
  );
endmodule

// File: rtl/sir_dec_chk.sv
module sir_dec_chk #(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_SLOTS   = 10,
  localparam int CNT_W  = $clog2(TICKS_PER_BIT),
  localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              en_i,
  input logic              cmd_mode_i,
  input logic              rx_o,
  input logic              active_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [SLOT_W-1:0] slot_i
);
  localparam logic [CNT_W-1:0]  HALF_C = CNT_W'(TICKS_PER_BIT / 2);
  localparam logic [SLOT_W-1:0] LAST_C = SLOT_W'(FRAME_SLOTS - 1);

  // R8
  rx_quiet_off_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && en_i && !cmd_mode_i) |=> $stable(rx_o));

  // R5
  rx_mid_slot_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && !cmd_mode_i && cnt_i != HALF_C) |=> $stable(rx_o));

  // R7
  hold_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || cmd_mode_i) |=> (rx_o && !active_i));

  // R6
  stop_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && tick_i && en_i && !cmd_mode_i && slot_i == LAST_C && cnt_i == HALF_C)
      |=> (rx_o && !active_i));

  // R2
  start_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_i) |-> (cnt_i == CNT_W'(1) && slot_i == '0 && rx_o));
endmodule

bind irda_sir_decoder sir_dec_chk #(
  .TICKS_PER_BIT(TICKS_PER_BIT),
  .FRAME_SLOTS  (FRAME_SLOTS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .en_i      (en_i),
  .cmd_mode_i(cmd_mode_i),
  .rx_o      (rx_o),
  .active_i  (run_active),
  .cnt_i     (tick_cnt),
  .slot_i    (slot_idx)
);

// File: tb/tb_irda_sir_decoder.sv
module tb_irda_sir_decoder;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic en_i = 1'b1;
  logic cmd_mode_i = 1'b0;
  logic rxir_i = 1'b1;
  logic rx_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irda_sir_decoder dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .en_i      (en_i),
    .cmd_mode_i(cmd_mode_i),
    .rxir_i    (rxir_i),
    .rx_o      (rx_o)
  );

  task automatic check(input logic exp, input string req, input int idx);
    n_cmp++;
    if (rx_o !== exp) begin
      n_bad++;
      $display("FAIL %s tick %0d: rx_o=%b expected %b", req, idx, rx_o, exp);
    end
  endtask

  // one bit-clock tick: line level set well ahead of the synchronizer, rx_o sampled after the tick edge
  task automatic do_tick(input logic ir);
    @(negedge clk_i);
    rxir_i = ir;
    tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic idle_ticks(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      do_tick(1'b1);
      check(1'b1, req, i);
    end
  endtask

  // 10-slot frame; late bits carry their pulse in the second half and must read as 1
  task automatic run_frame(input logic [7:0] data, input logic [7:0] late,
                           input int abort_at, input bit quiet);
    int   pos[10];
    int   len[10];
    logic bitv[10];
    logic ir;
    logic exp;
    string req;
    for (int s = 0; s < 10; s++) begin
      len[s] = 1 + int'($urandom_range(2, 0));
      pos[s] = -1;
      bitv[s] = 1'b1;
    end
    pos[0] = 0;
    bitv[0] = 1'b0;
    for (int b = 0; b < 8; b++) begin
      if (late[b]) begin
        pos[b+1] = 8 + int'($urandom_range(4, 0));
        bitv[b+1] = 1'b1;
      end else if (!data[b]) begin
        pos[b+1] = int'($urandom_range(5, 0));
        bitv[b+1] = 1'b0;
      end
    end
    for (int j = 0; j < 160; j++) begin
      int s = j / 16;
      int t = j % 16;
      ir = !(pos[s] >= 0 && t >= pos[s] && t < pos[s] + len[s]);
      if (j == abort_at) en_i = 1'b0;
      do_tick(ir);
      if (quiet || (abort_at >= 0 && j >= abort_at)) begin
        exp = 1'b1;
        req = "R7";
      end else if (j < 8) begin
        exp = 1'b1;
        req = "R2";
      end else if (j >= 152) begin
        exp = 1'b1;
        req = "R6";
      end else begin
        int b = (j - 8) / 16;
        exp = bitv[b];
        if (b == 0)               req = "R2";
        else if (late[b-1])       req = "R4";
        else if (!bitv[b])        req = "R3";
        else                      req = "R5";
      end
      check(exp, req, j);
    end
    en_i = 1'b1;
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, rx_o=%b expected completion", rx_o);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk_i);
    check(1'b1, "R1", -1);
    rst_ni = 1'b1;
    idle_ticks(4, "R1");

    // R8: clocks without ticks leave a line change unread
    rxir_i = 1'b0;
    repeat (20) @(negedge clk_i);
    check(1'b1, "R8", -2);
    rxir_i = 1'b1;
    idle_ticks(3, "R8");

    // fixed patterns: all zeros, all ones, alternating
    run_frame(8'h00, 8'h00, -1, 1'b0);
    idle_ticks(2, "R6");
    run_frame(8'hFF, 8'h00, -1, 1'b0);
    run_frame(8'h55, 8'h00, -1, 1'b0);
    idle_ticks(1, "R6");
    run_frame(8'hA5, 8'h3C, -1, 1'b0);

    // R6: line stuck low gives one all-zero frame, then no restart
    for (int j = 0; j < 200; j++) begin
      do_tick(1'b0);
      check((j < 8 || j >= 152) ? 1'b1 : 1'b0, "R6", j);
    end
    idle_ticks(3, "R6");

    // R7: command mode and disable
    cmd_mode_i = 1'b1;
    run_frame(8'h00, 8'h00, -1, 1'b1);
    cmd_mode_i = 1'b0;
    idle_ticks(2, "R7");
    run_frame(8'h0F, 8'h00, 45, 1'b0);
    idle_ticks(2, "R7");
    run_frame(8'h3A, 8'h00, -1, 1'b0);

    // random frames with random gaps and pulse offsets
    for (int f = 0; f < 24; f++) begin
      logic [7:0] d;
      logic [7:0] lt;
      d = 8'($urandom());
      lt = (f % 3 == 0) ? 8'($urandom()) : 8'h00;
      idle_ticks(int'($urandom_range(6, 0)), "R6");
      run_frame(d, lt, -1, 1'b0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule